// File: doc/BRIEF.md
# ADC Code Histogram Accumulator

This block measures converter linearity by building a histogram of output codes. Each incoming sample is conditioned in three steps. It is cut to the selected converter width, the top bit of that width is inverted so two's-complement codes become offset binary, and every bit above the width is forced to zero. The conditioned code selects one bin of a table kept in an external synchronous SRAM, and the block adds one to that bin with a read, increment and write sequence.

After reset the block first writes zero into every bin. It then counts samples until any one bin reaches a selectable ceiling. Each increment occupies the memory for twelve cycles, and samples that arrive during that window are dropped. When a bin reaches the ceiling, the block reads the table back in ascending bin order. Each count leaves through a byte-wide ready/valid port, most significant byte first. A one-cycle done pulse follows the final byte.

Top module: `adc_hist_acc`

## Requirements
- R1: After reset, `busy` is high for exactly 2^ADDR_W cycles. In each of those cycles the block writes zero to one address, ascending from 0, and no sample is counted.
- R2: `width_sel` picks the converter width: 00 = 18 bits, 01 = 16, 10 = 14, 11 = 12. The sample is cut to that width and the bit at position width-1 is inverted. All higher bits are zero.
- R3: The bin address is taken from the conditioned code. If the width exceeds ADDR_W, the address is the top ADDR_W bits of the code. Otherwise the address is the code itself, zero-extended.
- R4: A counted sample causes a read of its bin. In the next cycle the read value plus one is written to the same address.
- R5: Samples are counted only when they arrive with `smp_valid` high in a cycle where the block is free. After a counted sample, the samples of the following 11 cycles are discarded, so the next count can start 12 cycles later.
- R6: `limit_sel` sets the ceiling to LIMIT_MAX shifted right by its value: 00 = LIMIT_MAX, 01 = /2, 10 = /4, 11 = /8. Counting ends as soon as one bin is written with that value, and no bin ever exceeds it.
- R7: Readout sends every bin from address 0 upward. Each CNT_W-bit count is sent as CNT_W/8 bytes, most significant byte first.
- R8: While `byte_valid` is high and `byte_ready` is low, `byte_valid` stays high and `byte_data` does not change.
- R9: `done` is high for one cycle, in the cycle after the last byte of the last bin is accepted. No byte is offered after it.
- R10: Samples presented with `smp_valid` low are not counted, whatever their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 18 | Raw converter sample, two's complement |
| width_sel | input | 2 | Converter width select |
| limit_sel | input | 2 | Ceiling select |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | CNT_W | SRAM write data |
| mem_rdata | input | CNT_W | SRAM read data, one cycle after a read |
| byte_valid | output | 1 | Readout byte available |
| byte_data | output | 8 | Readout byte |
| byte_ready | input | 1 | Downstream accepts the byte |
| busy | output | 1 | Clear phase in progress |
| done | output | 1 | Readout complete pulse |

## Verification
The in-line properties check, on every cycle, the properties that follow from sequencing alone:
- the address advances by one during the clear phase;
- a write to the same address follows each read during accumulation;
- no written count exceeds the ceiling;
- a stalled byte stays stable;
- done lasts a single cycle.

Only the bench scenarios can show that the right samples were counted into the right bins. They do this by comparing the streamed counts with a model that applies the width conditioning, the twelve-cycle window and the stop rule, across all four widths and all four ceilings, with gaps in the valid strobe and back-pressure on the readout.

// File: rtl/adc_hist_acc.sv
module adc_hist_acc #(
  parameter int ADDR_W    = 15,
  parameter int CNT_W     = 24,
  parameter int LIMIT_MAX = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [17:0]       smp_data,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        limit_sel,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  mem_wdata,
  input  logic [CNT_W-1:0]  mem_rdata,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  input  logic              byte_ready,
  output logic              busy,
  output logic              done
);
  localparam int IN_W  = 18;
  localparam int WIN   = 12;
  localparam int NBYTE = CNT_W / 8;
  localparam int BI_W  = (NBYTE > 1) ? $clog2(NBYTE) : 1;

  typedef enum logic [1:0] {S_CLR, S_ACC, S_DUMP, S_END} st_t;

  st_t               st;
  logic [ADDR_W-1:0] ptr, cur;
  logic [3:0]        ph;
  logic [CNT_W-1:0]  shreg;
  logic [BI_W-1:0]   bidx;
  logic              obv, done_r;

  logic [4:0]        msb;
  logic [IN_W-1:0]   aligned, shifted;
  logic [ADDR_W-1:0] bin;
  int                sh;

  always_comb begin
    case (width_sel)
      2'b00:   msb = 5'd17;
      2'b01:   msb = 5'd15;
      2'b10:   msb = 5'd13;
      default: msb = 5'd11;
    endcase
    aligned = '0;
    for (int i = 0; i < IN_W; i++)
      if (i <= int'(msb)) aligned[i] = smp_data[i];
    aligned[msb] = ~smp_data[msb];
    sh = (int'(msb) + 1 > ADDR_W) ? int'(msb) + 1 - ADDR_W : 0;
    shifted = aligned >> sh;
    bin = ADDR_W'(shifted);
  end

  wire [CNT_W-1:0] limit    = CNT_W'(LIMIT_MAX >> limit_sel);
  wire [CNT_W-1:0] incr     = mem_rdata + CNT_W'(1);
  wire             acc_fire = (st == S_ACC) && (ph == 4'd0) && smp_valid;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    case (st)
      S_CLR: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
      end
      S_ACC: begin
        mem_addr = cur;
        if (ph == 4'd1) mem_en = 1'b1;
        if (ph == 4'd2) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = incr;
        end
      end
      S_DUMP: if (ph == 4'd0) mem_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_CLR;
      ptr    <= '0;
      cur    <= '0;
      ph     <= '0;
      shreg  <= '0;
      bidx   <= '0;
      obv    <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_CLR: begin
          ptr <= ptr + 1'b1;
          if (ptr == '1) st <= S_ACC;
        end
        S_ACC: begin
          if (acc_fire) begin
            cur <= bin;
            ph  <= 4'd1;
          end else if (ph != 4'd0) begin
            if (ph == 4'd2 && incr == limit) begin
              st <= S_DUMP;
              ph <= 4'd0;
            end else begin
              ph <= (ph == 4'(WIN - 1)) ? 4'd0 : ph + 4'd1;
            end
          end
        end
        S_DUMP: begin
          case (ph)
            4'd0: ph <= 4'd1;
            4'd1: begin
              shreg <= mem_rdata;
              bidx  <= '0;
              obv   <= 1'b1;
              ph    <= 4'd2;
            end
            default: if (obv && byte_ready) begin
              if (bidx == BI_W'(NBYTE - 1)) begin
                obv <= 1'b0;
                if (ptr == '1) begin
                  st     <= S_END;
                  done_r <= 1'b1;
                end else begin
                  ptr <= ptr + 1'b1;
                  ph  <= 4'd0;
                end
              end else begin
                shreg <= shreg << 8;
                bidx  <= bidx + 1'b1;
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  assign busy       = (st == S_CLR);
  assign byte_valid = obv;
  assign byte_data  = shreg[CNT_W-1 -: 8];
  assign done       = done_r;

  p_clear_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_addr != '1) |=> (busy && mem_addr == $past(mem_addr) + 1'b1));

  p_rmw_same_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACC && mem_en && !mem_we) |=> (mem_we && $stable(mem_addr)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !busy) |-> (mem_wdata <= limit));

  p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !byte_valid));
endmodule

// File: tb/adc_hist_acc_bench.sv
module adc_hist_acc_bench;
  localparam int CLK_NS    = 10;
  localparam int ADDR_W    = 5;
  localparam int CNT_W     = 24;
  localparam int LIMIT_MAX = 64;
  localparam int NBINS     = 1 << ADDR_W;
  localparam int NBYTE     = CNT_W / 8;
  localparam int WIN       = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [17:0]       smp_data = '0;
  logic [1:0]        width_sel = '0, limit_sel = '0;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [CNT_W-1:0]  mem_wdata;
  logic [CNT_W-1:0]  mem_rdata = '0;
  logic              byte_valid, byte_ready = 1'b0, busy, done;
  logic [7:0]        byte_data;
  logic [CNT_W-1:0]  mem [NBINS];

  int errs = 0, checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  adc_hist_acc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LIMIT_MAX(LIMIT_MAX)) u_adc_hist_acc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .width_sel(width_sel), .limit_sel(limit_sel),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .busy(busy), .done(done));

  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bin_of(int ws, logic [17:0] d);
    int w, code, sh;
    w = (ws == 0) ? 18 : (ws == 1) ? 16 : (ws == 2) ? 14 : 12;
    code = int'(d) & ((1 << w) - 1);
    code = code ^ (1 << (w - 1));
    sh = (w > ADDR_W) ? w - ADDR_W : 0;
    return (code >> sh) & (NBINS - 1);
  endfunction

  task automatic run(int ws, int ls, int mode);
    int refh [NBINS];
    int limit, k, last, nb, bi, ndone, maxc;
    bit stopped, finished, hold, v;
    logic [7:0] held;
    logic [17:0] d;
    longint word;
    limit = LIMIT_MAX >> ls;
    for (int i = 0; i < NBINS; i++) begin refh[i] = 0; mem[i] = 24'hA5A5A5; end
    width_sel = 2'(ws); limit_sel = 2'(ls);
    smp_valid = 1'b0; byte_ready = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && byte_valid == 1'b0 && done == 1'b0 && mem_addr == '0,
        "R1", "reset state busy", longint'(busy), 1);
    rst_n = 1'b1;
    k = 0; last = -100; nb = 0; bi = 0; ndone = 0; maxc = 0; word = 0;
    stopped = 0; finished = 0; hold = 0; held = '0;
    for (int it = 0; it < 60000 && !finished; it++) begin
      if (k < NBINS)
        chk(busy && mem_we && mem_wdata == '0 && int'(mem_addr) == k,
            "R1", "clear write address", longint'(mem_addr), k);
      else
        chk(!busy, "R1", "busy after clear", longint'(busy), 0);
      if (hold)
        chk(byte_valid && byte_data == held, "R8", "stalled byte", longint'(byte_data), longint'(held));
      if (done) begin
        ndone++;
        chk(nb == NBINS * NBYTE, "R9", "bytes before done", nb, NBINS * NBYTE);
        finished = 1;
      end
      case (mode)
        0: begin v = 1; d = 18'h3F000 | 18'((it * 37) & 12'hFFF); end
        1: begin v = ($urandom % 4) != 0; d = 18'($urandom); end
        2: begin v = (it % 3) != 0; d = v ? 18'h0 : 18'h1FFFF; end
        default: begin v = ($urandom % 2) != 0; d = 18'($urandom); end
      endcase
      smp_valid = v; smp_data = d;
      if (v && k >= NBINS && (k + 1) - last >= WIN && !stopped) begin
        refh[bin_of(ws, d)]++;
        last = k + 1;
        if (refh[bin_of(ws, d)] == limit) stopped = 1;
      end
      byte_ready = (mode == 1 || mode == 3) ? (($urandom % 2) != 0) : 1'b1;
      if (byte_valid && byte_ready) begin
        word = (word << 8) | longint'(byte_data);
        nb++;
        if (nb % NBYTE == 0) begin
          chk(word == longint'(refh[bi]), "R7", $sformatf("bin %0d count", bi), word, refh[bi]);
          if (int'(word) > maxc) maxc = int'(word);
          bi++; word = 0;
        end
      end
      hold = byte_valid && !byte_ready;
      held = byte_data;
      @(negedge clk);
      k++;
    end
    chk(finished, "R9", "done reached", longint'(finished), 1);
    chk(maxc == limit, "R6", "largest streamed count", maxc, limit);
    smp_valid = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(!done && !byte_valid, "R9", "quiet after done", longint'(byte_valid), 0);
    end
    chk(ndone == 1, "R9", "done pulses", ndone, 1);
  endtask

  initial begin
    #(CLK_NS * 190000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    run(3, 3, 0);  // R2 R3 12-bit, upper bits set, limit /8, R5 every cycle valid
    run(0, 0, 1);  // 18-bit random, full limit, back-pressure
    run(1, 2, 2);  // 16-bit constant code, R10 garbage while invalid
    run(2, 1, 3);  // 14-bit random, limit /2
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule